// File: doc/BRIEF.md
# SPI Frame-Length Command Decoder

This block is a write-only SPI slave. It has no command or address field: the number of SCLK rising edges counted while chip select is low decides what the frame does. An 8-bit frame replaces the whole configuration register. A DAC-length frame replaces the DAC code and raises a one-cycle load strobe. Any other length changes nothing.

The DAC frame length follows the DAC output mode held in the configuration register. In return-to-zero mode (mode bit clear, the reset state) a DAC frame is 14 bits long. In non-return-to-zero mode (mode bit set) it is 16 bits long. SCLK, MOSI and chip select are taken into the system clock through two-flop synchronisers. All decoding and every output belong to the system clock domain, so SCLK must run well below the system clock.

Top module: `spi_framelen_decoder`

## Requirements
- R1: After reset, `cfg_o` is 0, `dac_code_o` is 0 and `dac_load_o` is low.
- R2: A frame of exactly 8 bits writes its bits to `cfg_o`, shifted MSB first: the first bit clocked lands in bit 7.
- R3: `dac_nrtz_o` mirrors configuration bit 6, `clk_div_sel_o` mirrors bit 1 and `wave_shape_en_o` mirrors bit 5. Bit 6 picks the DAC frame length: 0 means 14 bits, 1 means 16 bits.
- R4: With bit 6 clear, a 14-bit frame loads `dac_code_o` left-justified. The first bit goes to bit 15, the 14 bits fill bits 15..2, and bits 1..0 are 0.
- R5: With bit 6 set, a 16-bit frame loads all 16 bits of `dac_code_o`, MSB first.
- R6: Each valid DAC frame raises `dac_load_o` for exactly one system clock cycle, in the same cycle that `dac_code_o` takes its new value. `dac_code_o` changes at no other time.
- R7: A frame whose length is neither 8 nor the active DAC length leaves `cfg_o` and `dac_code_o` unchanged and raises no strobe. This includes 0 bits, and a 16-bit frame in 14-bit mode or a 14-bit frame in 16-bit mode.
- R8: The bit counter saturates above 16, so every frame longer than 16 bits is invalid and changes nothing.
- R9: MOSI is sampled only on rising SCLK edges while chip select is low. SCLK activity while chip select is high has no effect.
- R10: Outputs change only after chip select is released. While a frame is still open, `cfg_o` and `dac_code_o` keep their old values and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| csn_i | input | 1 | Chip select, active low |
| cfg_o | output | 8 | Configuration register |
| clk_div_sel_o | output | 1 | DAC clock division select (config bit 1) |
| wave_shape_en_o | output | 1 | Transmit wave-shaping enable (config bit 5) |
| dac_nrtz_o | output | 1 | DAC non-return-to-zero mode (config bit 6) |
| dac_code_o | output | 16 | DAC code |
| dac_load_o | output | 1 | One-cycle strobe for a new DAC code |

## Verification
The bench builds the block with its default parameters: an 8-bit register, 16-bit and 14-bit DAC frames, mode bit 6, and two synchroniser stages. With these values both DAC modes can be reached by writing the register over SPI. Frame lengths from 0 to 24 bits are used, so the counter saturation matters: a 24-bit frame would wrap to 8 in a 4-bit counter. The cross cases are covered too, where a frame has the length of the DAC mode that is not active.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    // Number of flops in each input synchroniser chain
    localparam int unsigned SFD_SYNC_DEPTH = 2;

    // What a completed frame turns out to be
    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_CFG  = 2'd1,
        FK_DAC  = 2'd2
    } frame_kind_e;

endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
    parameter int unsigned          W       = 1,
    parameter int unsigned          DEPTH   = 2,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[g] <= RST_VAL;
                    else         stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[g] <= RST_VAL;
                    else         stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[DEPTH-1];

endmodule

// File: rtl/sfd_shifter.sv
module sfd_shifter #(
    parameter int unsigned MAX_BITS = 16,
    parameter int unsigned CNT_W    = $clog2(MAX_BITS + 2)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sclk_s_i,
    input  logic                mosi_s_i,
    input  logic                csn_s_i,
    output logic [MAX_BITS-1:0] shreg_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                release_o
);

    // Counting stops one above the longest legal frame
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BITS + 1);

    typedef struct packed {
        logic [MAX_BITS-1:0] shreg;
        logic [CNT_W-1:0]    count;
        logic                sclk_prev;
        logic                csn_prev;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         sclk_rise;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s_i;
        st_d.csn_prev  = csn_s_i;
        sclk_rise      = sclk_s_i & ~st_q.sclk_prev;
        release_o      = csn_s_i & ~st_q.csn_prev;

        if (csn_s_i) begin
            st_d.count = '0;
        end else if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[MAX_BITS-2:0], mosi_s_i};
            if (st_q.count != CNT_SAT) begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.shreg     <= '0;
            st_q.count     <= '0;
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg_o = st_q.shreg;
    assign count_o = st_q.count;

    // R8
    cnt_saturates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.count <= CNT_SAT);

    // R9
    idle_count_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csn_s_i |=> (st_q.count == '0));

endmodule

// File: rtl/sfd_decode.sv
module sfd_decode
    import sfd_pkg::*;
#(
    parameter int unsigned CFG_W     = 8,
    parameter int unsigned DAC_W     = 16,
    parameter int unsigned DAC_SHORT = 14,
    parameter int unsigned NRTZ_BIT  = 6,
    parameter int unsigned CNT_W     = $clog2(DAC_W + 2)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             release_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [DAC_W-1:0] shreg_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [DAC_W-1:0] dac_code_o,
    output logic             dac_load_o
);

    localparam logic [CNT_W-1:0] LEN_CFG   = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DAC_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DAC_SHORT);
    localparam int unsigned      PAD       = DAC_W - DAC_SHORT;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [DAC_W-1:0] code;
        logic             load;
    } dec_state_t;

    dec_state_t       st_d, st_q;
    frame_kind_e      kind;
    logic             nrtz;
    logic [CNT_W-1:0] dac_len;

    always_comb begin
        nrtz    = st_q.cfg[NRTZ_BIT];
        dac_len = nrtz ? LEN_LONG : LEN_SHORT;

        kind = FK_NONE;
        if (release_i) begin
            if (count_i == LEN_CFG)      kind = FK_CFG;
            else if (count_i == dac_len) kind = FK_DAC;
        end

        st_d      = st_q;
        st_d.load = 1'b0;
        case (kind)
            FK_CFG: st_d.cfg = shreg_i[CFG_W-1:0];
            FK_DAC: begin
                st_d.code = nrtz ? shreg_i : (shreg_i << PAD);
                st_d.load = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o      = st_q.cfg;
    assign dac_code_o = st_q.code;
    assign dac_load_o = st_q.load;

    // R6
    load_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.load |=> !st_q.load);

    // R6
    code_moves_with_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.code) |-> st_q.load);

    // R10
    cfg_waits_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !release_i |=> $stable(st_q.cfg));

    // R10
    load_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.load |-> $past(release_i));

endmodule

// File: rtl/spi_framelen_decoder.sv
module spi_framelen_decoder
    import sfd_pkg::*;
#(
    parameter int unsigned CFG_W        = 8,
    parameter int unsigned DAC_W        = 16,
    parameter int unsigned DAC_SHORT    = 14,
    parameter int unsigned NRTZ_BIT     = 6,
    parameter int unsigned CLK_DIV_BIT  = 1,
    parameter int unsigned SHAPE_BIT    = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sclk_i,
    input  logic             mosi_i,
    input  logic             csn_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             clk_div_sel_o,
    output logic             wave_shape_en_o,
    output logic             dac_nrtz_o,
    output logic [DAC_W-1:0] dac_code_o,
    output logic             dac_load_o
);

    localparam int unsigned CNT_W = $clog2(DAC_W + 2);

    logic [2:0]       pins_s;
    logic [DAC_W-1:0] shreg;
    logic [CNT_W-1:0] count;
    logic             frame_end;

    // order {csn, mosi, sclk}; chip select idles high
    sfd_sync #(
        .W       (3),
        .DEPTH   (SFD_SYNC_DEPTH),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({csn_i, mosi_i, sclk_i}),
        .sync_o  (pins_s)
    );

    sfd_shifter #(
        .MAX_BITS (DAC_W),
        .CNT_W    (CNT_W)
    ) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sclk_s_i  (pins_s[0]),
        .mosi_s_i  (pins_s[1]),
        .csn_s_i   (pins_s[2]),
        .shreg_o   (shreg),
        .count_o   (count),
        .release_o (frame_end)
    );

    sfd_decode #(
        .CFG_W     (CFG_W),
        .DAC_W     (DAC_W),
        .DAC_SHORT (DAC_SHORT),
        .NRTZ_BIT  (NRTZ_BIT),
        .CNT_W     (CNT_W)
    ) u_dec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .release_i  (frame_end),
        .count_i    (count),
        .shreg_i    (shreg),
        .cfg_o      (cfg_o),
        .dac_code_o (dac_code_o),
        .dac_load_o (dac_load_o)
    );

    assign clk_div_sel_o   = cfg_o[CLK_DIV_BIT];
    assign wave_shape_en_o = cfg_o[SHAPE_BIT];
    assign dac_nrtz_o      = cfg_o[NRTZ_BIT];

    // R7
    bad_length_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_end && count != CNT_W'(DAC_SHORT) && count != CNT_W'(DAC_W)) |=> !dac_load_o);

endmodule

// File: tb/tb_spi_framelen_decoder.sv
`timescale 1ns/1ps
module tb_spi_framelen_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        csn = 1'b1;
    logic [7:0]  cfg;
    logic        clk_div_sel, wave_shape_en, dac_nrtz;
    logic [15:0] dac_code;
    logic        dac_load;

    int n_checks = 0;
    int n_fail   = 0;
    int load_cnt = 0;

    logic [7:0]  exp_cfg  = '0;
    logic [15:0] exp_code = '0;

    always #5 clk = ~clk;

    spi_framelen_decoder dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .sclk_i          (sclk),
        .mosi_i          (mosi),
        .csn_i           (csn),
        .cfg_o           (cfg),
        .clk_div_sel_o   (clk_div_sel),
        .wave_shape_en_o (wave_shape_en),
        .dac_nrtz_o      (dac_nrtz),
        .dac_code_o      (dac_code),
        .dac_load_o      (dac_load)
    );

    always @(posedge clk) if (dac_load) load_cnt <= load_cnt + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Reference model for one completed frame
    function automatic int exp_loads(input int n);
        int dlen = exp_cfg[6] ? 16 : 14;
        return (n == dlen) ? 1 : 0;
    endfunction

    task automatic model(input int n, input logic [31:0] data);
        if (n == 8) exp_cfg = data[7:0];
        else if (n == 16 && exp_cfg[6]) exp_code = data[15:0];
        else if (n == 14 && !exp_cfg[6]) exp_code = {data[13:0], 2'b00};
    endtask

    task automatic send_frame(input int n, input logic [31:0] data);
        string tag;
        int    base, want;
        if (n == 8) tag = "R2";
        else if (n == 14 && !exp_cfg[6]) tag = "R4";
        else if (n == 16 && exp_cfg[6]) tag = "R5";
        else if (n > 16) tag = "R8";
        else tag = "R7";
        want = exp_loads(n);
        base = load_cnt;

        csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = data[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        // R10: nothing moves while the frame is open
        check(cfg == exp_cfg, "R10 cfg mid-frame", cfg, exp_cfg);
        check(dac_code == exp_code, "R10 code mid-frame", dac_code, exp_code);
        check(load_cnt == base, "R10 strobe mid-frame", load_cnt - base, 0);
        csn = 1'b1;
        repeat (10) @(negedge clk);

        model(n, data);
        check(cfg == exp_cfg, tag, cfg, exp_cfg);
        check(dac_code == exp_code, tag, dac_code, exp_code);
        check(load_cnt - base == want, "R6 strobe count", load_cnt - base, want);
        check({dac_nrtz, wave_shape_en, clk_div_sel} == {exp_cfg[6], exp_cfg[5], exp_cfg[1]},
              "R3 mirrors", {dac_nrtz, wave_shape_en, clk_div_sel},
              {exp_cfg[6], exp_cfg[5], exp_cfg[1]});
    endtask

    // R6: strobe never lasts more than one cycle
    logic load_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && dac_load && load_prev) check(1'b0, "R6 strobe width", 2, 1);
        load_prev = dac_load;
    end

    initial begin
        #2ms;
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int lens[11] = '{0, 3, 8, 9, 13, 14, 15, 16, 17, 20, 24};
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1
        check(cfg == 8'h00, "R1 cfg", cfg, 0);
        check(dac_code == 16'h0000, "R1 code", dac_code, 0);
        check(dac_load == 1'b0, "R1 strobe", dac_load, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Directed: config write, then 14-bit mode codes
        send_frame(8, 32'h0000_0022);          // R2 bits 1 and 5
        send_frame(14, 32'h0000_3FFF);         // R4 all ones
        send_frame(14, 32'h0000_2001);         // R4 first and last bit
        send_frame(16, 32'h0000_ABCD);         // R7 wrong length in 14-bit mode
        send_frame(0, 32'h0);                  // R7 empty frame
        send_frame(24, 32'h00AB_CD22);         // R8 long frame, low 8 look valid
        // R9: SCLK activity with chip select high
        for (int k = 0; k < 8; k++) begin
            mosi = k[0];
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
        end
        repeat (10) @(negedge clk);
        check(cfg == exp_cfg, "R9 idle sclk cfg", cfg, exp_cfg);
        check(dac_code == exp_code, "R9 idle sclk code", dac_code, exp_code);
        send_frame(8, 32'h0000_0062);          // R3 switch to 16-bit mode
        send_frame(16, 32'h0000_8001);         // R5
        send_frame(14, 32'h0000_1234);         // R7 short frame in 16-bit mode
        send_frame(17, 32'h0001_FFFF);         // R8
        send_frame(9, 32'h0000_01FF);          // R7

        // Random mix
        for (int r = 0; r < 60; r++) begin
            int n = lens[$urandom_range(0, 10)];
            logic [31:0] d = $urandom();
            if (n == 8 && ($urandom_range(0, 1) == 1)) d[6] = ~exp_cfg[6];
            send_frame(n, d);
        end
        summary();
    end

endmodule